// File: doc/BRIEF.md
# Link Rate Change Handshake Controller

This block is a per-lane controller on the MAC side of a PIPE-style interface. It carries out a change of link rate once higher-level logic has decided that a change is needed. A request arrives with a target rate code. The controller first stops transmit data. It then presents the new rate code to the PHY and runs a four-phase exchange on two signals: the PHY's clock-change-ok and the controller's acknowledge. The exchange closes when the PHY drops clock-change-ok and pulses phy-status in the same cycle. Only then does transmission resume.

Each wait for the PHY has a limit, set at run time in clock cycles. If a wait runs past that limit, the controller flags an error and returns to idle. The block also gates received data. The lane's data counts as valid only while its active-low reset-status indicator reads high and both data-valid flags are set.

Top module: `rate_xchg_ctrl`

## Requirements
- R1: After reset, tx_en_o is 1, rate_o is 0 (Gen1), and ack_o, busy_o, done_o and err_o are all 0.
- R2: A request with a legal target that differs from the current rate raises busy_o and drops tx_en_o one cycle after req_i is sampled, while rate_o still holds the old code. One cycle later rate_o shows the target. Codes 0, 1, 2, 3 and 4 mean Gen1 through Gen5.
- R3: ack_o rises in the cycle after clock-change-ok is first sampled high in the waiting phase, and never before rate_o carries the new code.
- R4: ack_o stays high for as long as clock-change-ok stays high. It falls in the cycle after clock-change-ok is sampled low.
- R5: When clock-change-ok is sampled low together with phy-status high, then in the next cycle done_o pulses for exactly one cycle, busy_o and ack_o fall, and tx_en_o returns to 1. err_o stays 0.
- R6: When clock-change-ok is sampled low while phy-status is low, the handshake ends the same way as in R5, except that err_o is set and done_o stays 0.
- R7: A request whose target equals the current rate pulses done_o in the next cycle. busy_o and ack_o stay 0, and tx_en_o stays 1.
- R8: A request whose target is above 4 sets err_o in the next cycle. rate_o is unchanged, busy_o stays 0, and tx_en_o stays 1.
- R9: A wait for clock-change-ok to rise, or to fall, times out after tmo_limit_i+1 cycles in that wait. The controller then returns to idle with ack_o at 0, busy_o at 0, tx_en_o at 1 and err_o at 1.
- R10: err_o is sticky. Any request sampled in idle clears it in the next cycle, unless that same request sets it again.
- R11: rx_valid_o is the AND of rx_rst_stat_n_i, rx_dv0_i and rx_dv1_i, with no added delay.
- R12: The same sequence applies to every pair of source and target codes from 0 to 4. Only the final value of rate_o differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Rate change request, sampled in idle |
| tgt_rate_i | input | 3 | Target rate code for the request |
| tmo_limit_i | input | 16 | Timeout limit for each wait, in cycles |
| busy_o | output | 1 | A rate change is in progress |
| done_o | output | 1 | One-cycle pulse when a change completes |
| err_o | output | 1 | Sticky error flag |
| tx_en_o | output | 1 | Transmit data is allowed |
| rate_o | output | 3 | Rate code presented to the PHY |
| pclk_ok_i | input | 1 | Clock-change-ok from the PHY |
| pclk_ack_o | output | 1 | Acknowledge to the PHY |
| phy_stat_i | input | 1 | PHY status completion pulse |
| rx_rst_stat_n_i | input | 1 | Lane reset-status from the PHY, high when out of reset |
| rx_dv0_i | input | 1 | Receive data-valid flag 0 |
| rx_dv1_i | input | 1 | Receive data-valid flag 1 |
| rx_valid_o | output | 1 | Qualified receive-valid |

## Verification
Every registered result appears one clock edge after the input that causes it is sampled. busy_o, done_o and err_o follow req_i by one cycle, and rate_o follows by two. ack_o follows a rising clock-change-ok by one cycle, and done_o or err_o follow a falling clock-change-ok by one cycle. A timeout fires tmo_limit_i+1 cycles after the wait begins. rx_valid_o is combinational and valid in the same cycle as its inputs. The bench changes inputs on the falling edge and reads outputs on the next falling edge, which falls after the clock edge that should produce the result. For timeouts it counts falling edges against the limit, so it sees both the last busy cycle and the first idle cycle.

// File: rtl/rate_xchg_pkg.sv
package rate_xchg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HALT    = 2'd1,
    ST_WAIT_OK = 2'd2,
    ST_ACK_HI  = 2'd3
  } xchg_st_e;
endpackage

// File: rtl/rate_xchg_tmr.sv
module rate_xchg_tmr #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_i,
  input  logic             clr_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             tmo_o
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (clr_i || !wait_i) cnt_d = '0;
    else if (cnt_q == CNT_MAX) begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end else cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tmo_o = wait_i && (cnt_q == limit_i);
endmodule

// File: rtl/rate_xchg_fsm.sv
module rate_xchg_fsm
  import rate_xchg_pkg::*;
#(
  parameter int RATE_W   = 3,
  parameter int MAX_RATE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [RATE_W-1:0] tgt_i,
  input  logic              pclk_ok_i,
  input  logic              phy_stat_i,
  input  logic              tmo_i,
  output logic              wait_o,
  output logic              clr_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              tx_en_o
);
  localparam logic [RATE_W-1:0] MAX_CODE = RATE_W'(MAX_RATE);

  xchg_st_e          st_q, st_d;
  logic [RATE_W-1:0] rate_q;
  logic              rate_ld, done_d, done_q, err_q, err_d, err_set, err_clr;

  always_comb begin
    st_d    = st_q;
    rate_ld = 1'b0;
    done_d  = 1'b0;
    err_set = 1'b0;
    err_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          err_clr = 1'b1;
          if (tgt_i > MAX_CODE) err_set = 1'b1;
          else if (tgt_i == rate_q) done_d = 1'b1;
          else st_d = ST_HALT;
        end
      end
      ST_HALT: begin
        st_d    = ST_WAIT_OK;
        rate_ld = 1'b1;
      end
      ST_WAIT_OK: begin
        if (pclk_ok_i) st_d = ST_ACK_HI;
        else if (tmo_i) begin
          st_d    = ST_IDLE;
          err_set = 1'b1;
        end
      end
      ST_ACK_HI: begin
        if (!pclk_ok_i) begin
          st_d = ST_IDLE;
          if (phy_stat_i) done_d = 1'b1;
          else err_set = 1'b1;
        end else if (tmo_i) begin
          st_d    = ST_IDLE;
          err_set = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    err_d = err_set ? 1'b1 : (err_clr ? 1'b0 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= '0;
    else if (rate_ld) rate_q <= tgt_i;
  end

  assign wait_o  = (st_q == ST_WAIT_OK) || (st_q == ST_ACK_HI);
  assign clr_o   = (st_d != st_q);
  assign rate_o  = rate_q;
  assign ack_o   = (st_q == ST_ACK_HI);
  assign busy_o  = (st_q != ST_IDLE);
  assign tx_en_o = (st_q == ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rate_xchg_rxq.sv
module rate_xchg_rxq #(
  parameter int DV_W = 2
) (
  input  logic            rst_stat_n_i,
  input  logic [DV_W-1:0] dv_i,
  output logic            valid_o
);
  assign valid_o = rst_stat_n_i && (&dv_i);
endmodule

// File: rtl/rate_xchg_ctrl.sv
module rate_xchg_ctrl #(
  parameter int RATE_W   = 3,
  parameter int MAX_RATE = 4,
  parameter int TMO_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [RATE_W-1:0] tgt_rate_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              tx_en_o,
  output logic [RATE_W-1:0] rate_o,
  input  logic              pclk_ok_i,
  output logic              pclk_ack_o,
  input  logic              phy_stat_i,
  input  logic              rx_rst_stat_n_i,
  input  logic              rx_dv0_i,
  input  logic              rx_dv1_i,
  output logic              rx_valid_o
);
  localparam int DV_W = 2;

  logic wait_s, clr_s, tmo_s;

  rate_xchg_fsm #(.RATE_W(RATE_W), .MAX_RATE(MAX_RATE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .tgt_i(tgt_rate_i),
    .pclk_ok_i(pclk_ok_i), .phy_stat_i(phy_stat_i), .tmo_i(tmo_s),
    .wait_o(wait_s), .clr_o(clr_s), .rate_o(rate_o), .ack_o(pclk_ack_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .tx_en_o(tx_en_o)
  );

  rate_xchg_tmr #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .wait_i(wait_s), .clr_i(clr_s),
    .limit_i(tmo_limit_i), .tmo_o(tmo_s)
  );

  rate_xchg_rxq #(.DV_W(DV_W)) u_rxq (
    .rst_stat_n_i(rx_rst_stat_n_i), .dv_i({rx_dv1_i, rx_dv0_i}),
    .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/rate_xchg_chk.sv
module rate_xchg_chk #(
  parameter int RATE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pclk_ok_i,
  input logic              pclk_ack_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              tx_en_o,
  input logic [RATE_W-1:0] rate_o,
  input logic              rx_rst_stat_n_i,
  input logic              rx_valid_o
);
  // R3
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pclk_ack_o) |-> $past(pclk_ok_i));
  // R4
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_ack_o) |-> (!$past(pclk_ok_i) || err_o));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && tx_en_o));
  // R2
  tx_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_ack_o |-> !tx_en_o);
  // R2
  rate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_o) |-> (!tx_en_o && !$past(tx_en_o)));
  // R11
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> rx_rst_stat_n_i);
endmodule

bind rate_xchg_ctrl rate_xchg_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pclk_ok_i(pclk_ok_i), .pclk_ack_o(pclk_ack_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .tx_en_o(tx_en_o),
  .rate_o(rate_o), .rx_rst_stat_n_i(rx_rst_stat_n_i), .rx_valid_o(rx_valid_o)
);

// File: tb/sim_rate_xchg_ctrl.sv
`timescale 1ns/1ps
module sim_rate_xchg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  tgt = 3'd0;
  logic [15:0] lim = 16'd20;
  logic        ok = 1'b0;
  logic        stat = 1'b0;
  logic        rs_n = 1'b0;
  logic        dv0 = 1'b0;
  logic        dv1 = 1'b0;
  logic        busy, done, err, tx_en, ack, rxv;
  logic [2:0]  rate;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int cur_rate = 0;

  always #2 clk = ~clk;

  rate_xchg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .tgt_rate_i(tgt), .tmo_limit_i(lim),
    .busy_o(busy), .done_o(done), .err_o(err), .tx_en_o(tx_en), .rate_o(rate),
    .pclk_ok_i(ok), .pclk_ack_o(ack), .phy_stat_i(stat),
    .rx_rst_stat_n_i(rs_n), .rx_dv0_i(dv0), .rx_dv1_i(dv1), .rx_valid_o(rxv)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // entry: tgt[8:6] delay-before-ok[5:2] mode[1:0]; mode 0 clean, 1 ok drops without status
  localparam int NV = 7;
  localparam logic [8:0] VEC [NV] = '{
    {3'd1, 4'd2, 2'd0}, {3'd4, 4'd0, 2'd0}, {3'd2, 4'd5, 2'd0},
    {3'd0, 4'd1, 2'd1}, {3'd3, 4'd3, 2'd0}, {3'd0, 4'd1, 2'd0},
    {3'd1, 4'd0, 2'd0}
  };

  task automatic run_change(input int t, input int dly, input int mode);
    step(); req = 1'b1; tgt = 3'(t);
    step(); req = 1'b0;
    check("R2 busy after req", busy, 1);
    check("R2 tx halted", tx_en, 0);
    check("R2 rate still old", rate, cur_rate);
    step();
    check("R2/R12 rate new", rate, t);
    check("R3 ack low before ok", ack, 0);
    for (int i = 0; i < dly; i++) step();
    check("R3 ack low while waiting", ack, 0);
    ok = 1'b1;
    step();
    check("R3 ack after ok", ack, 1);
    step(); step();
    check("R4 ack held", ack, 1);
    check("R2 tx still halted", tx_en, 0);
    ok = 1'b0; stat = (mode == 0);
    step(); stat = 1'b0;
    check("R4 ack dropped", ack, 0);
    check("R5 busy low", busy, 0);
    check("R5 tx resumed", tx_en, 1);
    check("R5/R6 done", done, (mode == 0) ? 1 : 0);
    check("R6 err", err, (mode == 1) ? 1 : 0);
    step();
    check("R5 done single pulse", done, 0);
    cur_rate = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    check("R1 tx_en", tx_en, 1);
    check("R1 rate", rate, 0);
    check("R1 ack", ack, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    rst_n = 1'b1;
    step();

    for (int v = 0; v < NV; v++)
      run_change(int'(VEC[v][8:6]), int'(VEC[v][5:2]), int'(VEC[v][1:0]));

    // R7 same rate
    step(); req = 1'b1; tgt = 3'(cur_rate);
    step(); req = 1'b0;
    check("R7 done", done, 1);
    check("R7 busy", busy, 0);
    check("R7 ack", ack, 0);
    check("R7 tx", tx_en, 1);
    step();
    check("R7 done pulse", done, 0);

    // R8 illegal target
    req = 1'b1; tgt = 3'd6;
    step(); req = 1'b0;
    check("R8 err", err, 1);
    check("R8 busy", busy, 0);
    check("R8 rate kept", rate, cur_rate);
    check("R8 tx", tx_en, 1);
    step(); step();
    check("R10 err sticky", err, 1);
    req = 1'b1; tgt = 3'(cur_rate);
    step(); req = 1'b0;
    check("R10 err cleared", err, 0);

    // R9 timeout waiting for ok to rise
    lim = 16'd5;
    req = 1'b1; tgt = 3'd2;
    step(); req = 1'b0;
    step();
    check("R9 rate", rate, 2);
    for (int i = 0; i < 5; i++) step();
    check("R9 busy at last wait cycle", busy, 1);
    step();
    check("R9 busy after timeout", busy, 0);
    check("R9 err", err, 1);
    check("R9 tx", tx_en, 1);
    cur_rate = 2;

    // R9 timeout waiting for ok to fall
    lim = 16'd4;
    req = 1'b1; tgt = 3'd0;
    step(); req = 1'b0;
    check("R10 err cleared by change", err, 0);
    step();
    ok = 1'b1;
    step();
    check("R9 ack up", ack, 1);
    for (int i = 0; i < 4; i++) step();
    check("R9 ack at last wait cycle", ack, 1);
    step();
    check("R9 ack released on timeout", ack, 0);
    check("R9 err hold", err, 1);
    check("R9 busy", busy, 0);
    ok = 1'b0;
    cur_rate = 0;
    lim = 16'd20;
    step();

    // R11 receive qualifier, all combinations
    for (int k = 0; k < 8; k++) begin
      rs_n = k[2]; dv1 = k[1]; dv0 = k[0];
      #1;
      check("R11 rx_valid", rxv, (k == 7) ? 1 : 0);
      step();
    end

    // R12 final wide jump after error recovery
    run_change(4, 1, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule